// File: doc/BRIEF.md
# Microcoded Accumulator-Immediate ALU Sequencer

This block executes the accumulator-with-immediate arithmetic family, one byte per handshake from an instruction byte queue. The opcode selects one of eight ALU operations, an operand width and a direction. A four-word micro-program loads the immediate into hidden temporary B, reads the selected register into temporary A, runs the ALU and writes the result back with a flags update. The micro-program names only a generic operation and a generic register. The operation comes from a latch filled from opcode bits 5:3. The register comes from two selector latches and a swap stage.

In the byte form, a micro-branch on the first step skips the high-immediate load. A 16-bit instruction therefore issues in four cycles and a byte instruction in three. The next opcode is accepted during the final micro-step, so consecutive instructions run with no gap. The register file sits outside the block: the block presents a read selector and takes the read data, and it drives a registered write port with byte strobes.

Top module: `useq_alu_core`

## Requirements
- R1: After reset, `rf_we` and `flag_upd` are low, `flags` is zero and `q_ready` is high.
- R2: An opcode of the form 00ooo1dw with w=1 is followed by two immediate bytes, low byte first. The result is written to the selected register with `rf_wstrb`=2'b11. Back-to-back 16-bit instructions produce one update every 4 cycles.
- R3: With w=0, only one immediate byte is taken and the high-byte step is skipped. The write carries `rf_wstrb`=2'b01 with `rf_wdata[15:8]`=0, and flags come from the low 8 bits. Back-to-back byte instructions produce one update every 3 cycles.
- R4: Opcode bits 5:3 select the operation: 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare. The result is the register operand combined with the immediate.
- R5: Compare (bits 5:3 = 7) updates the flags and raises `flag_upd`, but leaves `rf_we` low.
- R6: `flags` = {O,S,Z,C}, from bit 3 down to bit 0. C is the carry out for add/adc and the borrow for sub/sbb/cmp, and it is cleared for logic operations. O is signed overflow for arithmetic operations and cleared for logic operations. S is the result's top bit and Z is set when the result is zero.
- R7: Add-with-carry and subtract-with-borrow use, as carry-in, the C flag left by the previous flag update.
- R8: Opcode bit 1 (direction) set to 0 targets the accumulator selector `ACC_SEL` (default 0) for both the read and the write. Set to 1, the swap stage targets `ALT_SEL` (default 3) instead. `rf_rsel` presents the targeted selector.
- R9: While an immediate byte is needed and `q_valid` is low, the sequence holds. No update is issued, and the final result is the same as without the stall.
- R10: The next opcode is accepted in the cycle of the last micro-step, so no idle cycle separates consecutive instructions.
- R11: An opcode byte outside the family (bits 7:6 not 00, or bit 2 = 0) is consumed and discarded. It causes no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Queue byte present |
| q_byte | input | 8 | Queue byte |
| q_ready | output | 1 | Block takes the queue byte this cycle when `q_valid` is high |
| rf_rsel | output | 5 | Register file read selector |
| rf_rdata | input | 16 | Register file read data for `rf_rsel` |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 5 | Register write selector |
| rf_wdata | output | 16 | Register write data |
| rf_wstrb | output | 2 | Byte write strobes |
| flag_upd | output | 1 | One-cycle pulse when `flags` is updated |
| flags | output | 4 | Condition flags {O,S,Z,C} |

## Verification
The bench goes after the byte branch: a design that failed to take it would swallow the next opcode as a high immediate and desynchronise the whole stream. It also checks update spacing, which exposes a missing overlap of the last step with the next fetch, and compare, where a leaked write would corrupt a register that the bench's model still holds. Carry chains across add-with-carry and subtract-with-borrow catch a carry-in taken from the wrong place. Queue gaps in the middle of an immediate catch a step counter that advances without data, and filler bytes outside the family catch a decoder that acts on them.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ROM_DEPTH = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_OR  = 3'd1, OP_ADC = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_SUB = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7
  } alu_op_e;

  // flag bit positions inside the flags vector
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_S = 2;
  localparam int FL_O = 3;
  localparam int FL_W = 4;

  typedef struct packed {
    logic q_lo;     // queue byte into temp B low
    logic q_hi;     // queue byte into temp B high
    logic rd_m;     // selected register into temp A
    logic wr_m;     // ALU result into selected register
    logic br_byte;  // skip next step for byte width
    logic alu_go;   // latch operation for the ALU
    logic nxt;      // next-to-last step
    logic rni;      // last step, fetch next opcode
    logic flg;      // update flags
  } uword_t;

  function automatic uword_t ucode_word(input int step);
    uword_t w;
    w = '0;
    case (step)
      0: begin w.q_lo = 1'b1; w.br_byte = 1'b1; end
      1: begin w.q_hi = 1'b1; end
      2: begin w.rd_m = 1'b1; w.alu_go = 1'b1; w.nxt = 1'b1; end
      3: begin w.wr_m = 1'b1; w.rni = 1'b1; w.flg = 1'b1; end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_urom.sv
module useq_urom
  import useq_pkg::*;
#(
  parameter int UA_W = 8,
  parameter logic [UA_W-1:0] UBASE = 8'h18
) (
  input  logic [UA_W-1:0] uaddr,
  output uword_t          uword
);
  localparam int OFF_W = $clog2(ROM_DEPTH);
  localparam logic [UA_W-1:0] ULAST = UBASE + UA_W'(ROM_DEPTH - 1);

  uword_t tbl [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign tbl[i] = ucode_word(i);
  end

  logic [OFF_W-1:0] off;
  logic             hit;

  assign off   = OFF_W'(uaddr - UBASE);
  assign hit   = (uaddr >= UBASE) && (uaddr <= ULAST);
  assign uword = hit ? tbl[off] : '0;
endmodule

// File: rtl/useq_regsel.sv
module useq_regsel #(
  parameter int SEL_W = 5,
  parameter logic [SEL_W-1:0] ACC_SEL = 5'd0,
  parameter logic [SEL_W-1:0] ALT_SEL = 5'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dir_in,
  output logic [SEL_W-1:0] sel_eff
);
  logic [SEL_W-1:0] m_q, n_q, m_d, n_d;
  logic             dir_q;

  // load multiplexers: new instruction picks fixed codes, otherwise hold
  assign m_d = load ? ACC_SEL : m_q;
  assign n_d = load ? ALT_SEL : n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q   <= ACC_SEL;
      n_q   <= ALT_SEL;
      dir_q <= 1'b0;
    end else begin
      m_q <= m_d;
      n_q <= n_d;
      if (load) dir_q <= dir_in;
    end
  end

  // swap stage: direction exchanges the two latches
  assign sel_eff = dir_q ? n_q : m_q;
endmodule

// File: rtl/useq_alu.sv
module useq_alu
  import useq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  input  logic              byte_mode,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic [FL_W-1:0]   flg
);
  localparam int BYTE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] mask, a, b;
  logic [DATA_W:0]   s;
  logic              arith, is_sub, sa, sb, sr, cy;

  always_comb begin
    mask   = byte_mode ? LO_MASK : '1;
    a      = opa & mask;
    b      = opb & mask;
    arith  = 1'b1;
    is_sub = 1'b0;
    case (op)
      OP_ADD: s = {1'b0, a} + {1'b0, b};
      OP_ADC: s = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
      OP_SUB, OP_CMP: begin s = {1'b0, a} - {1'b0, b}; is_sub = 1'b1; end
      OP_SBB: begin s = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin}; is_sub = 1'b1; end
      OP_OR:  begin s = {1'b0, a | b}; arith = 1'b0; end
      OP_AND: begin s = {1'b0, a & b}; arith = 1'b0; end
      default: begin s = {1'b0, a ^ b}; arith = 1'b0; end
    endcase
    res = s[DATA_W-1:0] & mask;
    cy  = byte_mode ? s[BYTE_W] : s[DATA_W];
    sa  = byte_mode ? a[BYTE_W-1] : a[DATA_W-1];
    sb  = byte_mode ? b[BYTE_W-1] : b[DATA_W-1];
    sr  = byte_mode ? res[BYTE_W-1] : res[DATA_W-1];
    flg       = '0;
    flg[FL_C] = arith & cy;
    flg[FL_O] = arith & (is_sub ? (sa != sb) : (sa == sb)) & (sr != sa);
    flg[FL_S] = sr;
    flg[FL_Z] = (res == '0);
  end
endmodule

// File: rtl/useq_alu_core.sv
module useq_alu_core
  import useq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 5,
  parameter int UA_W   = 8,
  parameter logic [UA_W-1:0]  UBASE   = 8'h18,
  parameter logic [SEL_W-1:0] ACC_SEL = 5'd0,
  parameter logic [SEL_W-1:0] ALT_SEL = 5'd3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       q_valid,
  input  logic [DATA_W/2-1:0]        q_byte,
  output logic                       q_ready,
  output logic [SEL_W-1:0]           rf_rsel,
  input  logic [DATA_W-1:0]          rf_rdata,
  output logic                       rf_we,
  output logic [SEL_W-1:0]           rf_wsel,
  output logic [DATA_W-1:0]          rf_wdata,
  output logic [DATA_W/(DATA_W/2)-1:0] rf_wstrb,
  output logic                       flag_upd,
  output logic [FL_W-1:0]            flags
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int STRB_W = DATA_W / BYTE_W;
  localparam logic [UA_W-1:0] ULAST = UBASE + UA_W'(ROM_DEPTH - 1);

  logic              run;
  logic [UA_W-1:0]   uaddr, step_next;
  logic [2:0]        x_q;
  logic              wid_q;
  alu_op_e           op_q;
  logic [DATA_W-1:0] tmp_a, tmp_b, alu_res;
  logic [FL_W-1:0]   alu_flags;
  logic [SEL_W-1:0]  sel_m;
  uword_t            uw_rom, uw;
  logic              need_q, stall, take_op, in_family;

  useq_urom #(.UA_W(UA_W), .UBASE(UBASE)) u_rom (
    .uaddr(uaddr), .uword(uw_rom)
  );

  assign uw = run ? uw_rom : '0;

  assign need_q    = uw.q_lo | uw.q_hi;
  assign stall     = need_q & ~q_valid;
  assign q_ready   = ~run | need_q | uw.rni;
  assign take_op   = q_valid & (~run | uw.rni);
  assign in_family = (q_byte[7:6] == 2'b00) & q_byte[2];
  assign step_next = (uw.br_byte & ~wid_q) ? uaddr + UA_W'(2) : uaddr + UA_W'(1);

  useq_regsel #(.SEL_W(SEL_W), .ACC_SEL(ACC_SEL), .ALT_SEL(ALT_SEL)) u_sel (
    .clk(clk), .rst(rst), .load(take_op & in_family), .dir_in(q_byte[1]),
    .sel_eff(sel_m)
  );

  assign rf_rsel = sel_m;

  useq_alu #(.DATA_W(DATA_W)) u_alu (
    .opa(tmp_a), .opb(tmp_b), .op(op_q), .byte_mode(~wid_q),
    .cin(flags[FL_C]), .res(alu_res), .flg(alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      uaddr    <= UBASE;
      x_q      <= '0;
      wid_q    <= 1'b0;
      op_q     <= OP_ADD;
      tmp_a    <= '0;
      tmp_b    <= '0;
      rf_we    <= 1'b0;
      rf_wsel  <= '0;
      rf_wdata <= '0;
      rf_wstrb <= '0;
      flag_upd <= 1'b0;
      flags    <= '0;
    end else begin
      rf_we    <= 1'b0;
      flag_upd <= 1'b0;
      if (uw.q_lo && q_valid) tmp_b[BYTE_W-1:0]      <= q_byte;
      if (uw.q_hi && q_valid) tmp_b[DATA_W-1:BYTE_W] <= q_byte;
      if (uw.rd_m)   tmp_a <= rf_rdata;
      if (uw.alu_go) op_q  <= alu_op_e'(x_q);
      if (uw.wr_m) begin
        rf_we    <= (op_q != OP_CMP);
        rf_wsel  <= sel_m;
        rf_wdata <= alu_res;
        rf_wstrb <= wid_q ? {STRB_W{1'b1}} : STRB_W'(1);
      end
      if (uw.flg) begin
        flags    <= alu_flags;
        flag_upd <= 1'b1;
      end
      if (run && !uw.rni && !stall) uaddr <= step_next;
      if (take_op) begin
        if (in_family) begin
          run   <= 1'b1;
          uaddr <= UBASE;
          x_q   <= q_byte[5:3];
          wid_q <= q_byte[0];
        end else begin
          run <= 1'b0;
        end
      end else if (uw.rni) begin
        run <= 1'b0;
      end
    end
  end

  // R9: a missing queue byte freezes the step counter and temporaries
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(uaddr) && $stable(tmp_b) && $stable(tmp_a)));

  // R3: byte width skips the high-immediate step
  assert_byte_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (run && uw.br_byte && !wid_q && q_valid) |=> (uaddr == $past(uaddr) + UA_W'(2)));

  // R3: strobe is either full word or low byte only
  assert_strobe_shape_R3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wstrb == {STRB_W{1'b1}} || rf_wstrb == STRB_W'(1)));

  // R2: a write only follows a last micro-step
  assert_write_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(run && uw.rni));

  // R5: a flag update without a write comes only from compare
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && !rf_we) |-> ($past(op_q) == OP_CMP));

  // R10: next-to-last step is always followed by the last step
  assert_nxt_then_last_R10: assert property (@(posedge clk) disable iff (rst)
    (run && uw.nxt) |=> (run && uw.rni));

  // R2: running micro-address stays inside the routine
  assert_uaddr_range_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (uaddr >= UBASE && uaddr <= ULAST));
endmodule

// File: tb/useq_alu_core_tb.sv
`timescale 1ns/1ps
module useq_alu_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        q_valid = 1'b0;
  logic [7:0]  q_byte = 8'h00;
  logic        q_ready;
  logic [4:0]  rf_rsel;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_wsel;
  logic [15:0] rf_wdata;
  logic [1:0]  rf_wstrb;
  logic        flag_upd;
  logic [3:0]  flags;

  always #2 clk = ~clk;

  logic [15:0] regs  [32];
  logic [15:0] gregs [32];
  logic [3:0]  gflags;
  assign rf_rdata = regs[rf_rsel];

  useq_alu_core u_dut (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_byte(q_byte), .q_ready(q_ready),
    .rf_rsel(rf_rsel), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wsel(rf_wsel),
    .rf_wdata(rf_wdata), .rf_wstrb(rf_wstrb), .flag_upd(flag_upd), .flags(flags)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int upd_cnt = 0;
  int upd_cyc [$];
  logic        ev_we [$];
  logic [4:0]  ev_sel [$];
  logic [15:0] ev_data [$];
  logic [1:0]  ev_strb [$];
  logic [3:0]  ev_flags [$];
  logic [3:0]  ev_op [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) begin
      if (rf_wstrb[0]) regs[rf_wsel][7:0]  <= rf_wdata[7:0];
      if (rf_wstrb[1]) regs[rf_wsel][15:8] <= rf_wdata[15:8];
    end
  end

  // reference operation, written from the requirement text (R4, R6, R7)
  task automatic ref_op(input logic [2:0] op, input bit w, input logic [15:0] a, input logic [15:0] b,
                        input bit cin, output logic [15:0] r, output logic [3:0] f);
    int m, half, ua, ub, sa, sb, full, sr;
    bit c, ov, arith;
    m = w ? 32'hFFFF : 32'hFF;
    half = (m + 1) / 2;
    ua = int'(a) & m; ub = int'(b) & m;
    sa = (ua >= half) ? ua - 2 * half : ua;
    sb = (ub >= half) ? ub - 2 * half : ub;
    arith = 1; c = 0; full = 0; sr = 0;
    case (op)
      3'd0: begin full = ua + ub; sr = sa + sb; c = full > m; end
      3'd2: begin full = ua + ub + int'(cin); sr = sa + sb + int'(cin); c = full > m; end
      3'd3: begin full = ua - ub - int'(cin); sr = sa - sb - int'(cin); c = ua < ub + int'(cin); end
      3'd5, 3'd7: begin full = ua - ub; sr = sa - sb; c = ua < ub; end
      3'd1: begin full = ua | ub; arith = 0; end
      3'd4: begin full = ua & ub; arith = 0; end
      default: begin full = ua ^ ub; arith = 0; end
    endcase
    ov = arith && (sr >= half || sr < -half);
    r = 16'(full & m);
    f = {ov, r >= 16'(half), r == 16'h0, arith && c};
  endtask

  logic [7:0] stream [$];

  task automatic add_instr(input logic [2:0] op, input bit w, input bit d, input logic [15:0] imm);
    logic [15:0] r; logic [3:0] f; int sel;
    stream.push_back({2'b00, op, 1'b1, d, w});
    stream.push_back(imm[7:0]);
    if (w) stream.push_back(imm[15:8]);
    sel = d ? 3 : 0;
    ref_op(op, w, gregs[sel], imm, gflags[0], r, f);
    ev_we.push_back(op != 3'd7);
    ev_sel.push_back(5'(sel));
    ev_data.push_back(w ? r : {8'h00, r[7:0]});
    ev_strb.push_back(w ? 2'b11 : 2'b01);
    ev_flags.push_back(f);
    ev_op.push_back({1'b0, op});
    if (op != 3'd7) begin
      if (w) gregs[sel] = r; else gregs[sel][7:0] = r[7:0];
    end
    gflags = f;
  endtask

  task automatic add_junk(input logic [7:0] b);
    logic [7:0] j;
    j = b;
    if (j[7:6] == 2'b00) j[2] = 1'b0;
    stream.push_back(j);
  endtask

  task automatic feed(input logic [7:0] b, input int gap);
    repeat (gap) begin @(negedge clk); q_valid = 1'b0; end
    do begin
      @(negedge clk); q_valid = 1'b1; q_byte = b; #1;
    end while (!q_ready);
  endtask

  task automatic run_stream(input int gap_pct);
    while (stream.size() > 0) begin
      feed(stream.pop_front(), (($urandom % 100) < gap_pct) ? 1 + $urandom % 3 : 0);
    end
    @(negedge clk); q_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // monitor: each flag update is compared with the next expected event
  always @(negedge clk) begin
    if (!rst && flag_upd) begin
      upd_cnt++;
      upd_cyc.push_back(cyc);
      if (ev_we.size() == 0) begin
        chk(0, "R11 unexpected update", 32'(flags), 0);
      end else begin
        logic we_e; logic [4:0] sel_e; logic [15:0] d_e; logic [1:0] s_e; logic [3:0] f_e, op_e;
        we_e = ev_we.pop_front(); sel_e = ev_sel.pop_front(); d_e = ev_data.pop_front();
        s_e = ev_strb.pop_front(); f_e = ev_flags.pop_front(); op_e = ev_op.pop_front();
        chk(flags == f_e, $sformatf("R6 flags op%0d", op_e), 32'(flags), 32'(f_e));
        chk(rf_we == we_e, "R5 write enable", 32'(rf_we), 32'(we_e));
        if (we_e) begin
          chk(rf_wdata == d_e, $sformatf("R4 result op%0d", op_e), 32'(rf_wdata), 32'(d_e));
          chk(rf_wsel == sel_e, "R8 write selector", 32'(rf_wsel), 32'(sel_e));
          chk(rf_wstrb == s_e, "R3 strobe", 32'(rf_wstrb), 32'(s_e));
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int b0, n0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      regs[i] = v; gregs[i] = v;
    end
    gflags = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rf_we == 1'b0 && flag_upd == 1'b0, "R1 idle outputs", {rf_we, flag_upd}, 0);
    chk(flags == 4'h0, "R1 flags", 32'(flags), 0);
    chk(q_ready == 1'b1, "R1 ready", 32'(q_ready), 1);

    // R2/R10: back-to-back 16-bit instructions, one update every 4 cycles
    upd_cyc.delete();
    add_instr(3'd0, 1, 0, 16'h1234);
    add_instr(3'd5, 1, 0, 16'h0F0F);
    add_instr(3'd6, 1, 1, 16'hAAAA);
    add_instr(3'd1, 1, 0, 16'h8001);
    run_stream(0);
    chk(upd_cyc.size() == 4, "R2 update count", upd_cyc.size(), 4);
    for (int i = 1; i < upd_cyc.size(); i++)
      chk(upd_cyc[i] - upd_cyc[i-1] == 4, "R10 word spacing", upd_cyc[i] - upd_cyc[i-1], 4);

    // R3: byte instructions skip the high byte, one update every 3 cycles
    upd_cyc.delete();
    add_instr(3'd0, 0, 0, 16'h00F0);
    add_instr(3'd0, 0, 0, 16'h0020);
    add_instr(3'd4, 0, 1, 16'h003C);
    add_instr(3'd5, 0, 0, 16'h007F);
    run_stream(0);
    for (int i = 1; i < upd_cyc.size(); i++)
      chk(upd_cyc[i] - upd_cyc[i-1] == 3, "R3 byte spacing", upd_cyc[i] - upd_cyc[i-1], 3);

    // R7: carry chain: force carry then add-with-carry and subtract-with-borrow
    add_instr(3'd0, 1, 0, 16'hFFFF);
    add_instr(3'd2, 1, 0, 16'h0000);
    add_instr(3'd5, 1, 1, 16'hFFFF);
    add_instr(3'd3, 1, 1, 16'h0001);
    add_instr(3'd3, 0, 0, 16'h0080);
    // R5: compares leave registers alone
    add_instr(3'd7, 1, 0, 16'h5555);
    add_instr(3'd7, 0, 1, 16'h0001);
    // R11: filler bytes between instructions
    add_junk(8'h90);
    add_junk(8'h03);
    add_instr(3'd0, 1, 0, 16'h7FFF);
    add_junk(8'hC4);
    run_stream(0);

    // R9: stall in the middle of an immediate
    add_instr(3'd0, 1, 1, 16'h4321);
    feed(stream.pop_front(), 0);
    feed(stream.pop_front(), 0);
    n0 = upd_cnt;
    b0 = stream.size();
    feed(stream.pop_front(), 10);
    chk(upd_cnt == n0, "R9 no update during stall", upd_cnt, n0);
    chk(b0 == 1, "R9 stream shape", b0, 1);
    @(negedge clk); q_valid = 1'b0;
    repeat (8) @(negedge clk);

    // random mix with queue gaps
    for (int k = 0; k < 300; k++) begin
      if (($urandom % 100) < 12) add_junk(8'($urandom));
      else add_instr(3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    end
    run_stream(30);

    chk(ev_we.size() == 0, "R11 all expected updates seen", ev_we.size(), 0);
    for (int i = 0; i < 8; i++)
      chk(regs[i] == gregs[i], $sformatf("R2 register %0d final", i), 32'(regs[i]), 32'(gregs[i]));
    chk(flags == gflags, "R6 final flags", 32'(flags), 32'(gflags));
    finish_run();
  end
endmodule